// File: doc/BRIEF.md
# Synchronized phasor time-tag generator

This block keeps absolute time for a phasor measurement unit and marks the instants at which phasor reports are taken. A one-pulse-per-second input, already aligned to UTC and synchronous to the system clock, starts each second. A 32-bit seconds count advances on every such pulse. Software can also load it directly. If the pulse goes missing, the block keeps time on its own clock and flags the loss in the quality byte.

Inside each second the block issues `rate` evenly spaced report strobes. The first strobe lands exactly on the top of the second. Each strobe comes with a 64-bit time tag made of the seconds count, a fraction of second, and a quality byte. The fraction is counted against a wrap base that can be programmed, for example 2^24 counts per second or 1,000,000 for microsecond steps. The fraction of report k is the exact integer value floor(k·base/rate), so the rounding error never builds up over the second. The strobes are timing events, so they take no back-pressure. All pins are plain level or pulse signals, and the tag is meaningful in the cycle `rpt_stb` is high.

Top module: `phasor_timetag`

## Requirements
- R1: `rpt_tag` bits [63:32] carry the seconds count and bits [31:8] carry the fraction. The quality byte sits in bits [7:0]: bit 7 is the unlocked flag, bit 6 copies `leap_pend`, bit 5 copies `leap_sub` (1 means a second will be removed), bit 4 is 0, and bits [3:0] copy `clk_acc`.
- R2: A rising edge of `pps_i` (high in a cycle after a low one) starts a new second, and the seconds count increments by one (wrapping at 2^32). In the next cycle `rpt_stb` is high with a fraction of 0 and the new seconds value.
- R3: For k = 1 .. rate-1, report k is strobed ceil(k·CLK_HZ/rate) cycles after report 0 of the same second. No further report is strobed in that second.
- R4: The fraction of report k equals floor(k·base/rate), computed exactly for any base up to 2^24 and any rate from 1 to 255.
- R5: `cfg_base` and `cfg_rate` are sampled only when a second starts. A change in the middle of a second alters neither the spacing nor the fractions of the remaining reports of that second.
- R6: If no PPS edge arrives within CLK_HZ cycles of the start of a second, the block starts the next second on its own. The seconds count increments and report 0 is issued with fraction 0.
- R7: The unlocked flag is set from reset until the first PPS edge. It is set again once LOCK_TMO cycles pass with no PPS edge. A PPS edge clears it.
- R8: `sec_ld` writes `sec_val` into the seconds count at once, taking priority over an increment in the same cycle. The seconds count changes only by PPS edge, flywheel, or load. The leap inputs never alter it.
- R9: After reset the seconds count is 0 and no report is strobed until the first second starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, CLK_HZ cycles per nominal second |
| rst_n | input | 1 | Active-low synchronous reset |
| pps_i | input | 1 | One pulse per second, synchronous to clk |
| sec_ld | input | 1 | Load strobe for the seconds count |
| sec_val | input | 32 | Seconds value to load |
| cfg_base | input | BASE_W | Fraction wrap base (counts per second) |
| cfg_rate | input | RATE_W | Reports per second, at least 1 |
| leap_pend | input | 1 | Leap second pending, copied into quality |
| leap_sub | input | 1 | Leap direction, 1 = subtract, copied into quality |
| clk_acc | input | 4 | Clock accuracy code, copied into quality |
| rpt_stb | output | 1 | One-cycle report strobe |
| rpt_tag | output | 64 | Time tag: seconds, fraction, quality |

## Verification
The embedded properties assume three things about the inputs. `pps_i` is already synchronous to `clk`. `cfg_rate` is non-zero. It is also small enough that ceil(CLK_HZ/rate) exceeds the BASE_W+1 cycles the serial divider needs after each top of second. The bench reduces CLK_HZ to 2400 so that whole seconds fit in the run, and keeps rates at 60 or below so each report interval is at least 40 cycles. It spaces PPS edges just under one flywheel period, except in the scenario that deliberately withholds them to exercise the flywheel and the lock timeout.

// File: rtl/phasor_pkg.sv
package phasor_pkg;
  localparam int SEC_W  = 32;
  localparam int FRAC_W = 24;

  typedef struct packed {
    logic       unlocked;
    logic       leap_pend;
    logic       leap_sub;
    logic       rsvd;
    logic [3:0] acc;
  } qual_t;

  typedef struct packed {
    logic [SEC_W-1:0]  sec;
    logic [FRAC_W-1:0] frac;
    qual_t             qual;
  } tag_t;
endpackage

// File: rtl/phasor_div.sv
module phasor_div #(
  parameter int NW = 25,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [NW-1:0] num,
  input  logic [DW-1:0] den,
  output logic          busy,
  output logic [NW-1:0] quo,
  output logic [DW-1:0] rem
);
  localparam int CNT_W = $clog2(NW + 1);

  logic [NW-1:0]    sh_num;
  logic [NW-1:0]    quo_w;
  logic [DW-1:0]    part;
  logic [DW-1:0]    den_q;
  logic [CNT_W-1:0] cnt;
  logic [DW:0]      trial;
  logic             take;
  logic [DW-1:0]    part_nxt;

  always_comb begin
    trial    = {part, sh_num[NW-1]};
    take     = trial >= {1'b0, den_q};
    part_nxt = take ? DW'(trial - {1'b0, den_q}) : trial[DW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      sh_num <= '0;
      quo_w  <= '0;
      part   <= '0;
      den_q  <= DW'(1);
      cnt    <= '0;
      quo    <= '0;
      rem    <= '0;
    end else if (start) begin
      busy   <= 1'b1;
      sh_num <= num;
      den_q  <= den;
      part   <= '0;
      quo_w  <= '0;
      cnt    <= CNT_W'(NW);
    end else if (busy) begin
      sh_num <= sh_num << 1;
      part   <= part_nxt;
      quo_w  <= {quo_w[NW-2:0], take};
      cnt    <= cnt - CNT_W'(1);
      if (cnt == CNT_W'(1)) begin
        busy <= 1'b0;
        quo  <= {quo_w[NW-2:0], take};
        rem  <= part_nxt;
      end
    end
  end

  AST_DIV_REM_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> rem < den_q); // R4
endmodule

// File: rtl/phasor_epoch.sv
module phasor_epoch #(
  parameter int CLK_HZ   = 100_000_000,
  parameter int LOCK_TMO = 150_000_000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pps_i,
  input  logic        sec_ld,
  input  logic [31:0] sec_val,
  output logic        new_sec,
  output logic [31:0] sec,
  output logic        unlocked
);
  localparam int CYC_W = $clog2(CLK_HZ);
  localparam int TMO_W = $clog2(LOCK_TMO + 1);

  logic             pps_q;
  logic             pps_edge;
  logic [CYC_W-1:0] cyc;
  logic [TMO_W-1:0] tmo;

  always_comb begin
    pps_edge = pps_i & ~pps_q;
    new_sec  = pps_edge | (cyc == CYC_W'(CLK_HZ - 1));
    unlocked = (tmo == TMO_W'(LOCK_TMO));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pps_q <= 1'b0;
      cyc   <= '0;
      sec   <= '0;
      tmo   <= TMO_W'(LOCK_TMO);
    end else begin
      pps_q <= pps_i;
      cyc   <= new_sec ? '0 : cyc + CYC_W'(1);
      if (sec_ld)       sec <= sec_val;
      else if (new_sec) sec <= sec + 32'd1;
      if (pps_edge)      tmo <= '0;
      else if (!unlocked) tmo <= tmo + TMO_W'(1);
    end
  end

  AST_SEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    new_sec && !sec_ld |=> sec == $past(sec) + 32'd1); // R2
  AST_SEC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    sec_ld |=> sec == $past(sec_val)); // R8
  AST_SEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !new_sec && !sec_ld |=> $stable(sec)); // R8
  AST_PPS_RELOCK: assert property (@(posedge clk) disable iff (!rst_n)
    pps_edge |=> !unlocked); // R7
endmodule

// File: rtl/phasor_sched.sv
module phasor_sched #(
  parameter int CLK_HZ   = 100_000_000,
  parameter int RATE_W   = 8,
  parameter int BASE_W   = 25,
  parameter int FRAC_W   = 24,
  parameter int RATE_DEF = 10,
  parameter int BASE_DEF = 16_777_216
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              new_sec,
  input  logic [BASE_W-1:0] cfg_base,
  input  logic [RATE_W-1:0] cfg_rate,
  input  logic              div_busy,
  input  logic [BASE_W-1:0] div_quo,
  input  logic [RATE_W-1:0] div_rem,
  output logic              stb,
  output logic [FRAC_W-1:0] frac
);
  localparam int CW = $clog2(CLK_HZ + 2**RATE_W);

  logic [RATE_W-1:0] rate_q;
  logic [BASE_W-1:0] base_q;
  logic              armed;
  logic [RATE_W-1:0] k;
  logic [CW-1:0]     racc;
  logic [CW-1:0]     nxt;
  logic [RATE_W-1:0] frem;
  logic [RATE_W:0]   sum_rem;
  logic              carry;
  logic              more;
  logic              fire;

  always_comb begin
    nxt     = racc + CW'(rate_q);
    more    = armed && ({1'b0, k} + (RATE_W+1)'(1) < {1'b0, rate_q});
    fire    = more && (nxt >= CW'(CLK_HZ));
    sum_rem = {1'b0, frem} + {1'b0, div_rem};
    carry   = sum_rem >= {1'b0, rate_q};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rate_q <= RATE_W'(RATE_DEF);
      base_q <= BASE_W'(BASE_DEF);
      armed  <= 1'b0;
      k      <= '0;
      racc   <= '0;
      frac   <= '0;
      frem   <= '0;
      stb    <= 1'b0;
    end else if (new_sec) begin
      rate_q <= cfg_rate;
      base_q <= cfg_base;
      armed  <= 1'b1;
      k      <= '0;
      racc   <= '0;
      frac   <= '0;
      frem   <= '0;
      stb    <= 1'b1;
    end else begin
      stb <= fire;
      if (fire) begin
        racc <= nxt - CW'(CLK_HZ);
        k    <= k + RATE_W'(1);
        frac <= frac + FRAC_W'(div_quo) + FRAC_W'(carry);
        frem <= carry ? RATE_W'(sum_rem - {1'b0, rate_q}) : sum_rem[RATE_W-1:0];
      end else if (more) begin
        racc <= nxt;
      end
    end
  end

  AST_TOP_FRAC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    new_sec |=> stb && frac == '0); // R2
  AST_FRAC_BELOW_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    stb |-> BASE_W'(frac) < base_q); // R4
  AST_K_BELOW_RATE: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> k < rate_q); // R3
  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !new_sec |=> $stable(rate_q) && $stable(base_q)); // R5
  AST_DIV_READY: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> !div_busy); // R4
endmodule

// File: rtl/phasor_timetag.sv
module phasor_timetag
  import phasor_pkg::*;
#(
  parameter int CLK_HZ   = 100_000_000,
  parameter int LOCK_TMO = 150_000_000,
  parameter int RATE_W   = 8,
  parameter int BASE_W   = 25,
  parameter int RATE_DEF = 10,
  parameter int BASE_DEF = 16_777_216
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pps_i,
  input  logic              sec_ld,
  input  logic [31:0]       sec_val,
  input  logic [BASE_W-1:0] cfg_base,
  input  logic [RATE_W-1:0] cfg_rate,
  input  logic              leap_pend,
  input  logic              leap_sub,
  input  logic [3:0]        clk_acc,
  output logic              rpt_stb,
  output logic [63:0]       rpt_tag
);
  logic              new_sec;
  logic [SEC_W-1:0]  sec;
  logic              unlocked;
  logic              div_busy;
  logic [BASE_W-1:0] div_quo;
  logic [RATE_W-1:0] div_rem;
  logic [FRAC_W-1:0] frac;
  tag_t              tag;

  phasor_epoch #(.CLK_HZ(CLK_HZ), .LOCK_TMO(LOCK_TMO)) u_epoch (
    .clk(clk), .rst_n(rst_n), .pps_i(pps_i), .sec_ld(sec_ld),
    .sec_val(sec_val), .new_sec(new_sec), .sec(sec), .unlocked(unlocked)
  );

  phasor_div #(.NW(BASE_W), .DW(RATE_W)) u_div (
    .clk(clk), .rst_n(rst_n), .start(new_sec), .num(cfg_base),
    .den(cfg_rate), .busy(div_busy), .quo(div_quo), .rem(div_rem)
  );

  phasor_sched #(
    .CLK_HZ(CLK_HZ), .RATE_W(RATE_W), .BASE_W(BASE_W), .FRAC_W(FRAC_W),
    .RATE_DEF(RATE_DEF), .BASE_DEF(BASE_DEF)
  ) u_sched (
    .clk(clk), .rst_n(rst_n), .new_sec(new_sec), .cfg_base(cfg_base),
    .cfg_rate(cfg_rate), .div_busy(div_busy), .div_quo(div_quo),
    .div_rem(div_rem), .stb(rpt_stb), .frac(frac)
  );

  always_comb begin
    tag.sec            = sec;
    tag.frac           = frac;
    tag.qual.unlocked  = unlocked;
    tag.qual.leap_pend = leap_pend;
    tag.qual.leap_sub  = leap_sub;
    tag.qual.rsvd      = 1'b0;
    tag.qual.acc       = clk_acc;
    rpt_tag            = tag;
  end
endmodule

// File: tb/sim_phasor_timetag.sv
module sim_phasor_timetag;
  localparam int CLK  = 2400;
  localparam int TMO  = 3000;
  localparam int LOGN = 128;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pps_i = 1'b0;
  logic        sec_ld = 1'b0;
  logic [31:0] sec_val = '0;
  logic [24:0] cfg_base = 25'd16777216;
  logic [7:0]  cfg_rate = 8'd10;
  logic        leap_pend = 1'b0;
  logic        leap_sub = 1'b0;
  logic [3:0]  clk_acc = 4'h3;
  logic        rpt_stb;
  logic [63:0] rpt_tag;

  int n_chk = 0;
  int n_err = 0;
  longint cyc = 0;
  int lg_n = 0;
  longint lg_cyc [LOGN];
  logic [63:0] lg_tag [LOGN];

  phasor_timetag #(.CLK_HZ(CLK), .LOCK_TMO(TMO)) u0 (
    .clk(clk), .rst_n(rst_n), .pps_i(pps_i), .sec_ld(sec_ld), .sec_val(sec_val),
    .cfg_base(cfg_base), .cfg_rate(cfg_rate), .leap_pend(leap_pend),
    .leap_sub(leap_sub), .clk_acc(clk_acc), .rpt_stb(rpt_stb), .rpt_tag(rpt_tag)
  );

  always #2 clk = ~clk;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (rpt_stb && lg_n < LOGN) begin
      lg_cyc[lg_n] = cyc;
      lg_tag[lg_n] = rpt_tag;
      lg_n = lg_n + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_pps();
    @(negedge clk) pps_i = 1'b1;
    @(negedge clk) pps_i = 1'b0;
  endtask

  task automatic load_sec(input logic [31:0] v);
    @(negedge clk) begin sec_ld = 1'b1; sec_val = v; end
    @(negedge clk) sec_ld = 1'b0;
  endtask

  task automatic chk_second(input int n_exp, input longint base, input int rate,
                            input logic [31:0] sec_exp, input logic [7:0] q_exp);
    chk(lg_n == n_exp, "R3 count", lg_n, n_exp);
    for (int k = 0; k < lg_n && k < n_exp; k++) begin
      longint off  = lg_cyc[k] - lg_cyc[0];
      longint eoff = (longint'(k) * CLK + rate - 1) / rate;
      longint efr  = (longint'(k) * base) / rate;
      chk(off == eoff, "R3 offset", off, eoff);
      chk(lg_tag[k][31:8] == efr, (k == 0) ? "R2 frac0" : "R4 frac",
          lg_tag[k][31:8], efr);
      chk(lg_tag[k][63:32] == sec_exp, "R2 sec", lg_tag[k][63:32], sec_exp);
      chk(lg_tag[k][7:0] == q_exp, "R1 qual", lg_tag[k][7:0], q_exp);
    end
  endtask

  task automatic t_reset();
    waitc(50);
    chk(lg_n == 0, "R9 no strobe", lg_n, 0);
    chk(rpt_tag[63:32] == 0, "R9 sec", rpt_tag[63:32], 0);
    chk(rpt_tag[7] == 1'b1, "R7 unlocked at reset", rpt_tag[7], 1);
  endtask

  task automatic t_rate60();
    cfg_base = 25'd16777216; cfg_rate = 8'd60;
    load_sec(32'd1000);
    lg_n = 0;
    pulse_pps();
    waitc(2380);
    chk_second(60, 16777216, 60, 32'd1001, 8'h03);
    chk(lg_tag[1][31:8] == 24'd279620, "R4 second report", lg_tag[1][31:8], 279620);
  endtask

  task automatic t_midchange();
    cfg_base = 25'd1000000; cfg_rate = 8'd30;
    lg_n = 0;
    pulse_pps();
    waitc(300);
    cfg_base = 25'd1000; cfg_rate = 8'd12;
    waitc(2080);
    chk_second(30, 1000000, 30, 32'd1002, 8'h03); // R5
  endtask

  task automatic t_rate12();
    lg_n = 0;
    pulse_pps();
    waitc(2380);
    chk_second(12, 1000, 12, 32'd1003, 8'h03); // R5 applied at next second
  endtask

  task automatic t_rate1_wrap();
    cfg_base = 25'd16777216; cfg_rate = 8'd1;
    load_sec(32'hFFFF_FFFF);
    lg_n = 0;
    pulse_pps();
    waitc(2380);
    chk_second(1, 16777216, 1, 32'd0, 8'h03); // R2 wrap, R3 single report
  endtask

  task automatic t_load_priority();
    cfg_base = 25'd16777216; cfg_rate = 8'd25;
    leap_pend = 1'b1; leap_sub = 1'b1; clk_acc = 4'hA;
    lg_n = 0;
    @(negedge clk) begin pps_i = 1'b1; sec_ld = 1'b1; sec_val = 32'd500; end
    @(negedge clk) begin pps_i = 1'b0; sec_ld = 1'b0; end
    waitc(2380);
    chk_second(25, 16777216, 25, 32'd500, 8'h6A); // R8 load wins, R1 quality
    leap_pend = 1'b0; leap_sub = 1'b0; clk_acc = 4'h3;
  endtask

  task automatic t_flywheel();
    cfg_rate = 8'd1;
    lg_n = 0;
    pulse_pps();
    waitc(5000);
    chk(lg_n == 3, "R6 flywheel count", lg_n, 3);
    if (lg_n >= 3) begin
      chk(lg_cyc[1] - lg_cyc[0] == CLK, "R6 period 1", lg_cyc[1] - lg_cyc[0], CLK);
      chk(lg_cyc[2] - lg_cyc[0] == 2 * CLK, "R6 period 2", lg_cyc[2] - lg_cyc[0], 2 * CLK);
      chk(lg_tag[1][63:32] == 32'd502, "R6 sec 1", lg_tag[1][63:32], 502);
      chk(lg_tag[2][63:32] == 32'd503, "R6 sec 2", lg_tag[2][63:32], 503);
      chk(lg_tag[1][31:8] == 0, "R6 frac0", lg_tag[1][31:8], 0);
      chk(lg_tag[1][7] == 1'b0, "R7 still locked", lg_tag[1][7], 0);
      chk(lg_tag[2][7] == 1'b1, "R7 timeout", lg_tag[2][7], 1);
    end
  endtask

  task automatic t_relock();
    cfg_base = 25'd1000000; cfg_rate = 8'd10;
    lg_n = 0;
    pulse_pps();
    waitc(2380);
    chk_second(10, 1000000, 10, 32'd504, 8'h03); // R7 cleared by PPS
  endtask

  initial begin
    waitc(4);
    rst_n = 1'b1;
    t_reset();
    t_rate60();
    t_midchange();
    t_rate12();
    t_rate1_wrap();
    t_load_priority();
    t_flywheel();
    t_relock();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    waitc(150000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule